// File: doc/BRIEF.md
# Ring Network Node Interface

This block is the network access point that sits between one compute core and a unidirectional ring of nodes. Each cycle it takes at most one flit from the upstream ring link. A flit carries a destination node, a source node, a two-bit kind and a 16-bit payload. A flit addressed to another node is passed on to the downstream link one cycle later, unchanged. A flit addressed to this node is delivered to the core: program words go to the instruction memory, control commands hold the core in reset or release it, and data bytes go to the core's input queue.

Node 0 is the management node. Every byte the core emits is wrapped in a data flit toward node 0 and carries this node's ID as its source. Traffic already on the ring always has the downstream slot first, so the core's byte is taken only in a cycle when nothing is being forwarded. If the input queue is full when a data flit arrives, the flit is not dropped and does not stall the ring. It is forwarded and makes another lap.

Top module: `ring_node`

## Requirements
- R1: After reset the downstream link is idle (`tx_valid`=0) and `core_hold`=1, so the core is held in reset.
- R2: A valid upstream flit whose destination differs from `MY_ID` appears on the downstream link on the next cycle, with destination, source, kind and payload unchanged.
- R3: In any cycle in which an upstream flit is being forwarded, `out_ready` is 0 and the core's byte is not injected. When no flit is forwarded, `out_ready` is 1.
- R4: A byte accepted (`out_valid`=1 and `out_ready`=1) appears on the next cycle as a flit with destination 0, source `MY_ID`, kind 2 (data), payload bits 7:0 equal to the byte and payload bits 15:8 zero.
- R5: A local flit of kind 0 (load) writes the instruction memory in the same cycle. The address is payload bits 15:4 and the nibble is payload bits 3:0. The write happens only while `core_hold`=1. Otherwise the flit is discarded with no write and is not forwarded.
- R6: A local flit of kind 2 (data) pushes payload bits 7:0 into the input queue in the same cycle when `inq_full`=0. When `inq_full`=1 it is not pushed and is forwarded unchanged on the next cycle.
- R7: A local flit of kind 1 (control) with payload bit 0 = 1 clears `core_hold` from the next cycle. With bit 0 = 0 it sets `core_hold`. The flit is not forwarded.
- R8: A local flit of kind 3 is discarded: no write, no push, no forwarding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Upstream flit present |
| rx_dst | input | 8 | Upstream flit destination node |
| rx_src | input | 8 | Upstream flit source node |
| rx_kind | input | 2 | Upstream flit kind: 0 load, 1 control, 2 data, 3 unused |
| rx_data | input | 16 | Upstream flit payload |
| tx_valid | output | 1 | Downstream flit present |
| tx_dst | output | 8 | Downstream flit destination node |
| tx_src | output | 8 | Downstream flit source node |
| tx_kind | output | 2 | Downstream flit kind |
| tx_data | output | 16 | Downstream flit payload |
| imem_we | output | 1 | Instruction memory write strobe |
| imem_addr | output | 12 | Instruction memory write address |
| imem_nibble | output | 4 | Instruction memory write data |
| core_hold | output | 1 | Core held in reset |
| inq_full | input | 1 | Core input queue cannot accept a byte |
| inq_push | output | 1 | Push strobe into core input queue |
| inq_byte | output | 8 | Byte pushed into core input queue |
| out_valid | input | 1 | Core has an output byte |
| out_byte | input | 8 | Core output byte |
| out_ready | output | 1 | Core output byte accepted this cycle |

## Verification
The hardest situation to reach is the one where a local data flit meets a full input queue in the same cycle that the core is offering a byte. Here the flit has to be forwarded, and the core's byte has to wait. The random stimulus aims about a third of the flits at this node and holds `inq_full` high about half the time, with `out_valid` mostly high, so this collision happens many times. Directed steps also cover a load arriving while the core is running, a load after a reset command, and kind 3 flits.

// File: rtl/ring_node.sv
module ring_node #(
  parameter int NODE_W    = 8,
  parameter int PAYLOAD_W = 16,
  parameter int IMEM_AW   = 12,
  parameter logic [NODE_W-1:0] MY_ID = 8'd5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_valid,
  input  logic [NODE_W-1:0]    rx_dst,
  input  logic [NODE_W-1:0]    rx_src,
  input  logic [1:0]           rx_kind,
  input  logic [PAYLOAD_W-1:0] rx_data,
  output logic                 tx_valid,
  output logic [NODE_W-1:0]    tx_dst,
  output logic [NODE_W-1:0]    tx_src,
  output logic [1:0]           tx_kind,
  output logic [PAYLOAD_W-1:0] tx_data,
  output logic                 imem_we,
  output logic [IMEM_AW-1:0]   imem_addr,
  output logic [3:0]           imem_nibble,
  output logic                 core_hold,
  input  logic                 inq_full,
  output logic                 inq_push,
  output logic [7:0]           inq_byte,
  input  logic                 out_valid,
  input  logic [7:0]           out_byte,
  output logic                 out_ready
);
  localparam logic [1:0] K_LOAD = 2'd0;
  localparam logic [1:0] K_CTRL = 2'd1;
  localparam logic [1:0] K_DATA = 2'd2;
  localparam int NIB_W = 4;
  localparam int BYTE_W = 8;
  localparam logic [NODE_W-1:0] MGMT_ID = '0;

  logic mine, forward, inject;

  assign mine     = rx_valid && (rx_dst == MY_ID);
  assign forward  = rx_valid && (!mine || (rx_kind == K_DATA && inq_full));
  assign inject   = out_valid && !forward;
  assign out_ready = !forward;

  assign imem_we     = mine && rx_kind == K_LOAD && core_hold;
  assign imem_addr   = rx_data[NIB_W +: IMEM_AW];
  assign imem_nibble = rx_data[NIB_W-1:0];

  assign inq_push = mine && rx_kind == K_DATA && !inq_full;
  assign inq_byte = rx_data[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_hold <= 1'b1;
    end else if (mine && rx_kind == K_CTRL) begin
      core_hold <= !rx_data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_dst   <= '0;
      tx_src   <= '0;
      tx_kind  <= '0;
      tx_data  <= '0;
    end else if (forward) begin
      tx_valid <= 1'b1;
      tx_dst   <= rx_dst;
      tx_src   <= rx_src;
      tx_kind  <= rx_kind;
      tx_data  <= rx_data;
    end else if (inject) begin
      tx_valid <= 1'b1;
      tx_dst   <= MGMT_ID;
      tx_src   <= MY_ID;
      tx_kind  <= K_DATA;
      tx_data  <= {{(PAYLOAD_W-BYTE_W){1'b0}}, out_byte};
    end else begin
      tx_valid <= 1'b0;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !tx_valid && core_hold);

  a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_dst != MY_ID |=> tx_valid && tx_dst == $past(rx_dst)
      && tx_src == $past(rx_src) && tx_data == $past(rx_data));

  a_r3_no_inject_over_through: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_dst != MY_ID |-> !out_ready);

  a_r4_inject_tagged: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> tx_valid && tx_dst == MGMT_ID && tx_src == MY_ID
      && tx_data[BYTE_W-1:0] == $past(out_byte));

  a_r5_load_while_held: assert property (@(posedge clk) disable iff (!rst_n)
    imem_we |-> core_hold);

  a_r6_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    inq_push |-> !inq_full);

  a_r6_full_circulates: assert property (@(posedge clk) disable iff (!rst_n)
    mine && rx_kind == K_DATA && inq_full |=> tx_valid && tx_data == $past(rx_data)
      && tx_dst == MY_ID);

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    mine && rx_kind == K_CTRL && rx_data[0] |=> !core_hold);
endmodule

// File: tb/ring_node_test.sv
module ring_node_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] ID = 8'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_dst = '0, rx_src = '0;
  logic [1:0] rx_kind = '0;
  logic [15:0] rx_data = '0;
  logic tx_valid;
  logic [7:0] tx_dst, tx_src;
  logic [1:0] tx_kind;
  logic [15:0] tx_data;
  logic imem_we;
  logic [11:0] imem_addr;
  logic [3:0] imem_nibble;
  logic core_hold;
  logic inq_full = 1'b0;
  logic inq_push;
  logic [7:0] inq_byte;
  logic out_valid = 1'b0;
  logic [7:0] out_byte = '0;
  logic out_ready;

  int total = 0;
  int bad = 0;
  logic exp_hold;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_node #(.MY_ID(ID)) uut (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_dst(rx_dst), .rx_src(rx_src), .rx_kind(rx_kind), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_dst(tx_dst), .tx_src(tx_src), .tx_kind(tx_kind), .tx_data(tx_data),
    .imem_we(imem_we), .imem_addr(imem_addr), .imem_nibble(imem_nibble), .core_hold(core_hold),
    .inq_full(inq_full), .inq_push(inq_push), .inq_byte(inq_byte),
    .out_valid(out_valid), .out_byte(out_byte), .out_ready(out_ready));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic is_fwd(input logic v, input logic [7:0] d, input logic [1:0] k,
                                  input logic full);
    return v && (d != ID || (k == 2'd2 && full));
  endfunction

  task automatic step(input logic v, input logic [7:0] d, input logic [7:0] s,
                      input logic [1:0] k, input logic [15:0] p, input logic full,
                      input logic ov, input logic [7:0] ob);
    logic loc, fwd, we, push;
    rx_valid = v; rx_dst = d; rx_src = s; rx_kind = k; rx_data = p;
    inq_full = full; out_valid = ov; out_byte = ob;
    #1;
    loc  = v && d == ID;
    fwd  = is_fwd(v, d, k, full);
    we   = loc && k == 2'd0 && exp_hold;
    push = loc && k == 2'd2 && !full;
    chk("R3 out_ready", out_ready, !fwd);
    chk("R5 imem_we", imem_we, we);
    if (we) chk("R5 addr/nibble", {imem_addr, imem_nibble}, p);
    chk("R6 inq_push", inq_push, push);
    if (push) chk("R6 inq_byte", inq_byte, p[7:0]);
    @(posedge clk); #1;
    if (loc && k == 2'd1) exp_hold = !p[0];
    chk("R7 core_hold", core_hold, exp_hold);
    if (fwd) begin
      chk("R2 fwd flit", {tx_valid, tx_dst, tx_src, tx_kind, tx_data}, {1'b1, d, s, k, p});
    end else if (ov) begin
      chk("R4 inject flit", {tx_valid, tx_dst, tx_src, tx_kind, tx_data},
          {1'b1, 8'd0, ID, 2'd2, 8'd0, ob});
    end else begin
      chk("R8 idle link", tx_valid, 1'b0);
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    exp_hold = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 tx_valid", tx_valid, 1'b0);
    chk("R1 core_hold", core_hold, 1'b1);
    rst_n = 1'b1;
    // R5 load while held
    step(1, ID, 0, 2'd0, 16'hABC7, 0, 0, 8'h00);
    // R3 through traffic wins over a pending byte
    step(1, 8'd9, 8'd2, 2'd2, 16'h1234, 0, 1, 8'h55);
    // R4 free slot injects
    step(0, 0, 0, 0, 0, 0, 1, 8'hA5);
    // R7 release, then load is dropped while running
    step(1, ID, 0, 2'd1, 16'h0001, 0, 0, 0);
    step(1, ID, 0, 2'd0, 16'h0123, 0, 0, 0);
    // R6 full queue circulates while core offers a byte
    step(1, ID, 0, 2'd2, 16'h00EE, 1, 1, 8'h77);
    step(1, ID, 0, 2'd2, 16'h00EE, 0, 1, 8'h77);
    // R8 kind 3 discarded
    step(1, ID, 0, 2'd3, 16'hFFFF, 0, 0, 0);
    // R7 hold again, load accepted
    step(1, ID, 0, 2'd1, 16'h0000, 0, 0, 0);
    step(1, ID, 0, 2'd0, 16'hFFF0, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d;
      int r;
      r = $urandom_range(0, 2);
      d = (r == 0) ? ID : (r == 1) ? 8'd0 : 8'($urandom);
      step($urandom_range(0, 3) != 0, d, 8'($urandom), 2'($urandom), 16'($urandom),
           $urandom_range(0, 1) == 1, $urandom_range(0, 3) != 0, 8'($urandom));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule